// File: doc/BRIEF.md
# Single-Bit Test-and-Modify Unit

This block carries out one of four single-bit operations on a destination operand in one registered step: test the bit, set it, clear it, or invert it. Each operation first reads the addressed bit of the destination. The zero condition flag is then loaded with the inverse of that original bit, so the test and the change form a single combined operation. The destination is either a full 32-bit register or one memory byte. A flag on the input selects which, and that choice sets how the bit number wraps.

The unit sits between operand fetch and write-back in an execution pipeline. An input valid/ready handshake accepts one operation per cycle. Its result, a write-enable for the destination and the updated condition flags come out of a single output register stage. That stage has its own valid/ready handshake, so it can stall under back-pressure. Instruction decoding and memory sequencing are done elsewhere.

Top module: `btm_unit`

## Requirements
- R1: After reset `out_valid_o` is low and `in_ready_o` is high.
- R2: The bit index is `bit_num_i` modulo 32 when `is_byte_i` is 0 (register destination), and `bit_num_i` modulo 8 when `is_byte_i` is 1 (byte destination).
- R3: Bit 2 of `flags_o` (zero flag) is 1 when the addressed bit of `dest_i` was 0 before modification, and 0 when it was 1, for every operation.
- R4: Operation code 2'b00 (test) returns `dest_i` unchanged on `result_o` with `wr_en_o` low.
- R5: Operation codes 2'b01 (invert), 2'b10 (clear) and 2'b11 (set) return `dest_i` with only the addressed bit inverted, forced to 0 or forced to 1 respectively, with `wr_en_o` high.
- R6: Bits 4, 3, 1 and 0 of `flags_o` equal the same bits of `flags_i` captured with the operation.
- R7: In byte mode, bits 31:8 of `result_o` equal those of `dest_i`.
- R8: An operation is taken on a clock edge where `in_valid_i` and `in_ready_o` are both high. Its outputs appear with `out_valid_o` high after that edge. They stay stable while `out_valid_o` is high and `out_ready_i` is low, and `in_ready_o` is low during such a stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Operation offered |
| in_ready_o | output | 1 | Operation can be taken |
| op_i | input | 2 | 00 test, 01 invert, 10 clear, 11 set |
| bit_num_i | input | 6 | Bit number before wrapping |
| dest_i | input | 32 | Destination operand |
| is_byte_i | input | 1 | 1: byte destination, 0: 32-bit register |
| flags_i | input | 5 | Current condition flags, zero flag at bit 2 |
| out_valid_o | output | 1 | Result held in output stage |
| out_ready_i | input | 1 | Consumer takes the result |
| result_o | output | 32 | Destination after the operation |
| wr_en_o | output | 1 | Result should be written back |
| flags_o | output | 5 | Updated condition flags |

## Verification
On every accepted operation, the assertions check that:
- a test never writes back and returns the operand unchanged;
- modifying operations always write;
- at most one bit of the result differs from the operand;
- the non-zero flags pass through;
- the output stage holds its value and deasserts ready under back-pressure.

The following need the bench's scenarios, which compute expected values arithmetically:
- the exact zero-flag value;
- which bit is chosen after wrapping modulo 8 or 32;
- the direction of each change.

The bench covers these with a full sweep of operation, bit number, width mode and several operand and flag patterns, plus a stall sequence.

// File: rtl/btm_pkg.sv
package btm_pkg;
  typedef enum logic [1:0] {
    BTM_TEST = 2'b00,
    BTM_FLIP = 2'b01,
    BTM_CLR  = 2'b10,
    BTM_SET  = 2'b11
  } btm_op_e;

  localparam int FLAG_W   = 5;
  localparam int ZERO_POS = 2;
endpackage

// File: rtl/btm_bit_sel.sv
module btm_bit_sel #(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  parameter int NUM_W  = 6
) (
  input  logic [NUM_W-1:0]  bit_num_i,
  input  logic              is_byte_i,
  output logic [DATA_W-1:0] mask_o
);
  localparam int WIDX_W = $clog2(DATA_W);
  localparam int BIDX_W = $clog2(BYTE_W);

  logic [WIDX_W-1:0] idx;

  // byte destinations wrap on the byte width, registers on the word width
  always_comb begin
    idx = '0;
    if (is_byte_i) idx[BIDX_W-1:0] = bit_num_i[BIDX_W-1:0];
    else           idx = bit_num_i[WIDX_W-1:0];
  end

  always_comb begin
    mask_o = '0;
    mask_o[idx] = 1'b1;
  end
endmodule

// File: rtl/btm_bit_alu.sv
module btm_bit_alu
  import btm_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  btm_op_e           op_i,
  input  logic [DATA_W-1:0] dest_i,
  input  logic [DATA_W-1:0] mask_i,
  output logic [DATA_W-1:0] result_o,
  output logic              wr_en_o,
  output logic              old_bit_o
);
  assign old_bit_o = |(dest_i & mask_i);

  always_comb begin
    unique case (op_i)
      BTM_FLIP: result_o = dest_i ^ mask_i;
      BTM_CLR:  result_o = dest_i & ~mask_i;
      BTM_SET:  result_o = dest_i | mask_i;
      default:  result_o = dest_i;
    endcase
    wr_en_o = (op_i != BTM_TEST);
  end
endmodule

// File: rtl/btm_out_reg.sv
module btm_out_reg #(
  parameter int PAY_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [PAY_W-1:0] in_data_i,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic [PAY_W-1:0] out_data_o
);
  logic             valid_q;
  logic [PAY_W-1:0] data_q;

  assign in_ready_o  = !valid_q || out_ready_i;
  assign out_valid_o = valid_q;
  assign out_data_o  = data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else if (in_ready_o) begin
      valid_q <= in_valid_i;
      if (in_valid_i) data_q <= in_data_i;
    end
  end
endmodule

// File: rtl/btm_unit.sv
module btm_unit
  import btm_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  parameter int NUM_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [1:0]        op_i,
  input  logic [NUM_W-1:0]  bit_num_i,
  input  logic [DATA_W-1:0] dest_i,
  input  logic              is_byte_i,
  input  logic [FLAG_W-1:0] flags_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [DATA_W-1:0] result_o,
  output logic              wr_en_o,
  output logic [FLAG_W-1:0] flags_o
);
  localparam int PAY_W = DATA_W + 1 + FLAG_W;

  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] res_d;
  logic              we_d;
  logic              old_bit;
  logic [FLAG_W-1:0] flags_d;
  logic [PAY_W-1:0]  pay_d, pay_q;

  btm_bit_sel #(.DATA_W(DATA_W), .BYTE_W(BYTE_W), .NUM_W(NUM_W)) sel_i (
    .bit_num_i (bit_num_i),
    .is_byte_i (is_byte_i),
    .mask_o    (mask)
  );

  btm_bit_alu #(.DATA_W(DATA_W)) alu_i (
    .op_i      (btm_op_e'(op_i)),
    .dest_i    (dest_i),
    .mask_i    (mask),
    .result_o  (res_d),
    .wr_en_o   (we_d),
    .old_bit_o (old_bit)
  );

  // zero flag reflects the bit before modification; others pass through
  always_comb begin
    flags_d           = flags_i;
    flags_d[ZERO_POS] = ~old_bit;
  end

  assign pay_d = {we_d, flags_d, res_d};

  btm_out_reg #(.PAY_W(PAY_W)) oreg_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid_i),
    .in_ready_o  (in_ready_o),
    .in_data_i   (pay_d),
    .out_valid_o (out_valid_o),
    .out_ready_i (out_ready_i),
    .out_data_o  (pay_q)
  );

  assign result_o = pay_q[DATA_W-1:0];
  assign flags_o  = pay_q[DATA_W +: FLAG_W];
  assign wr_en_o  = pay_q[PAY_W-1];
endmodule

// File: rtl/btm_unit_chk.sv
module btm_unit_chk
  import btm_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  parameter int NUM_W  = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_valid_i,
  input logic              in_ready_o,
  input logic [1:0]        op_i,
  input logic [NUM_W-1:0]  bit_num_i,
  input logic [DATA_W-1:0] dest_i,
  input logic              is_byte_i,
  input logic [FLAG_W-1:0] flags_i,
  input logic              out_valid_o,
  input logic              out_ready_i,
  input logic [DATA_W-1:0] result_o,
  input logic              wr_en_o,
  input logic [FLAG_W-1:0] flags_o
);
  localparam logic [FLAG_W-1:0] KEEP = ~(FLAG_W'(1) << ZERO_POS);

  logic take;
  assign take = in_valid_i && in_ready_o;

  AST_ACCEPT_SHOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take |=> out_valid_o); // R8
  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(result_o)
      && $stable(flags_o) && $stable(wr_en_o)); // R8
  AST_STALL_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |-> !in_ready_o); // R8
  AST_TEST_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take && op_i == 2'b00 |=> !wr_en_o && result_o == $past(dest_i)); // R4
  AST_MODIFY_WRITES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take && op_i != 2'b00 |=> wr_en_o); // R5
  AST_ONE_BIT_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take |=> $countones(result_o ^ $past(dest_i)) <= 1); // R5
  AST_FLAGS_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take |=> (flags_o & KEEP) == ($past(flags_i) & KEEP)); // R6
  AST_BYTE_UPPER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take && is_byte_i |=> result_o[DATA_W-1:BYTE_W] == $past(dest_i[DATA_W-1:BYTE_W])); // R7
endmodule

bind btm_unit btm_unit_chk #(.DATA_W(DATA_W), .BYTE_W(BYTE_W), .NUM_W(NUM_W)) chk_i (.*);

// File: tb/btm_unit_tb_top.sv
module btm_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  op = '0;
  logic [5:0]  bit_num = '0;
  logic [31:0] dest = '0;
  logic        is_byte = 1'b0;
  logic [4:0]  flags = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] result;
  logic        wr_en;
  logic [4:0]  flags_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  btm_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .op_i(op), .bit_num_i(bit_num), .dest_i(dest), .is_byte_i(is_byte),
    .flags_i(flags), .out_valid_o(out_valid), .out_ready_i(out_ready),
    .result_o(result), .wr_en_o(wr_en), .flags_o(flags_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_res(input logic [1:0] o, input int idx, input logic [31:0] d);
    logic [31:0] r = d;
    case (o)
      2'b01: r[idx] = ~d[idx];
      2'b10: r[idx] = 1'b0;
      2'b11: r[idx] = 1'b1;
      default: r = d;
    endcase
    return r;
  endfunction

  // offer one operation at negedge, check outputs at next negedge
  task automatic run_op(input logic [1:0] o, input logic [5:0] bn, input logic [31:0] d,
                        input logic byt, input logic [4:0] f);
    int idx;
    logic [4:0] ef;
    @(negedge clk);
    op = o; bit_num = bn; dest = d; is_byte = byt; flags = f; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    idx = byt ? int'(bn % 8) : int'(bn % 32);
    ef = f;
    ef[2] = ~d[idx];
    chk("R8 out_valid", 32'(out_valid), 32'd1);
    chk(o == 2'b00 ? "R4 result" : (byt ? "R7/R2/R5 result" : "R2/R5 result"),
        result, exp_res(o, idx, d));
    chk(o == 2'b00 ? "R4 wr_en" : "R5 wr_en", 32'(wr_en), 32'(o != 2'b00));
    chk("R3 zero flag", 32'(flags_out[2]), 32'(ef[2]));
    chk("R6 other flags", 32'(flags_out & 5'b11011), 32'(ef & 5'b11011));
  endtask

  initial begin
    logic [31:0] pats [4];
    logic [31:0] a_res;
    pats[0] = 32'h0000_0000; pats[1] = 32'hFFFF_FFFF;
    pats[2] = 32'hA5C3_5A3C; pats[3] = 32'h1234_8001;
    #(CLK_PERIOD*2 + 1);
    // R1 reset state
    chk("R1 out_valid", 32'(out_valid), 32'd0);
    chk("R1 in_ready", 32'(in_ready), 32'd1);
    @(negedge clk);
    rst_n = 1'b1;
    for (int p = 0; p < 4; p++)
      for (int b = 0; b < 2; b++)
        for (int o = 0; o < 4; o++)
          for (int n = 0; n < 64; n++)
            run_op(2'(o), 6'(n), pats[p], 1'(b), 5'(n + p * 7 + o));
    // R8 stall: hold result A while B waits
    @(negedge clk);
    out_ready = 1'b0;
    op = 2'b11; bit_num = 6'd5; dest = 32'h0; is_byte = 1'b0; flags = 5'b0; in_valid = 1'b1;
    @(negedge clk);
    a_res = 32'h0000_0020;
    chk("R8 stall valid", 32'(out_valid), 32'd1);
    chk("R8 stall ready low", 32'(in_ready), 32'd0);
    op = 2'b10; bit_num = 6'd0; dest = 32'hFFFF_FFFF;
    @(negedge clk);
    @(negedge clk);
    chk("R8 stall hold result", result, a_res);
    chk("R8 stall hold wr_en", 32'(wr_en), 32'd1);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R8 second result", result, 32'hFFFF_FFFE);
    @(negedge clk);
    chk("R8 drained", 32'(out_valid), 32'd0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule